// File: doc/BRIEF.md
# Programmable Clock Output Divider Matrix

This block sits behind a clock multiplier and turns one fast source clock and one reference clock into six output pairs. Six dividers are shared by all pairs: fixed ratios of 1, 2, 3 and 4, a programmable ratio X, and twice X. A single divider-source bit decides whether these dividers count the multiplier clock or the reference. Each pair picks one of eight sources with a 3-bit code: a divider, the raw reference, or a lock indicator level. A pair can also invert its even output, which turns it into a complementary pair. A disabled pair holds both outputs low.

Four configuration sets are stored. A 2-bit personality input chooses the live set at any time. A set holds the six per-pair words (code, enable, invert), the X value and the divider-source bit. A simple write port loads the sets, including the live one. Source and lock inputs are treated as levels sampled by the block clock. Each divider counts edges of its source, both rising and falling. It holds its output high for the first N edges of every 2N, so every ratio, odd or even, gives a 50 % duty cycle. An output rise always falls on a source rise.

The shared dividers use two states. DV_WAIT_RISE holds the output low and moves to DV_COUNT on the next source rise. DV_COUNT counts source edges and goes back to DV_WAIT_RISE on a rearm, which fires whenever the live X value or divider source changes. Each pair uses two states. PS_STEADY moves to PS_PENDING when the requested setting differs from the applied one and the change cannot be made yet. PS_PENDING goes back to PS_STEADY once the change is applied, or when the request returns to the applied value. A change is applied only in a cycle where the old selected level and the new one are both low. This means no shortened pulse reaches an output.

Top module: `clk_div_matrix`

## Requirements
- R1: Pair code selects the pair source. The codes are 0 for reference, 1/2/3/4 for divide by 1/2/3/4, 5 for divide by X, 6 for divide by 2X, and 7 for lock indicator.
- R2: A divide-by-N output is high for N source edges and low for N source edges, counting rising and falling edges. Divide by 3 of a 4-cycle source is therefore high 6 cycles out of 12.
- R3: An X value written below 5 is stored as 5, and one written above 130 is stored as 130.
- R4: Divider-source bit 0 makes the dividers count the source clock, and 1 makes them count the reference. With 1, divide by 1 equals the reference code output.
- R5: The personality input selects the live set of the four, at once. The write port uses an address for the set and a field address within it. Field addresses 0 to 5 are pairs A10, A32, A54, B10, B32, B54, with data bits [2:0] code, [3] enable and [4] invert. Field address 6 is X, taken from data [7:0]. Field address 7 is the divider source, taken from data bit 0. A write takes effect on the next cycle.
- R6: With invert set on an enabled pair, the even output is the complement of the odd output.
- R7: With code 7, both outputs follow the lock input when the pair is not inverted. When it is inverted, the even output is low and the odd output is high while locked.
- R8: A disabled pair drives both outputs low, whatever its invert bit.
- R9: A new pair setting is applied only in a cycle where the old and the new selected levels are both low. A disabled setting counts as low. The odd output is low in the cycle of the change.
- R10: Divider outputs rise only on a source rise, so pairs on the same divider are edge-aligned. A change of live X or divider source clears all dividers, and they restart on the next source rise.
- R11: After reset all outputs are low and every set holds code 1, enabled, not inverted, X = 5 and source clock selected.
- R12: A level change on a source, reference or lock input reaches a selected output on the third rising clock edge after it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock sampling all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_in | input | 1 | Fast source clock level from the multiplier |
| ref_in | input | 1 | Reference clock level |
| lock_in | input | 1 | Multiplier lock level |
| persona | input | 2 | Live configuration set select |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_set | input | 2 | Set addressed by a write |
| cfg_addr | input | 3 | Field addressed within the set |
| cfg_data | input | 8 | Write data |
| pair_even | output | 6 | Even output of each pair (A10, A32, A54, B10, B32, B54) |
| pair_odd | output | 6 | Odd output of each pair |

## Verification
Odd divide ratios are measured for high time and period. A counter that counted only rising edges would give a skewed duty cycle or a wrong period. X values of 3 and 200 are written and the resulting periods are measured. A missing clamp gives a divide by 3 or a wrapped count. The bench switches personality every few cycles while the lock input is stuck high. A design that applied changes at once would show runt pulses, and one that waited on the wrong level would stall or swap early; either one leaves the cycle model. Inverted lock pairs, disabled inverted pairs and reference-driven divide by 1 are each compared against their required levels.

// File: rtl/clkmx_pkg.sv
package clkmx_pkg;

    localparam int NUM_PAIRS = 6;
    localparam int NUM_SETS  = 4;
    localparam int NUM_DIVS  = 6;
    localparam int CODE_W    = 3;
    localparam int NUM_SRC   = 1 << CODE_W;
    localparam int XVAL_W    = 8;
    localparam int X_LO      = 5;
    localparam int X_HI      = 130;

    typedef enum logic [CODE_W-1:0] {
        SRC_REF  = 3'd0,
        SRC_D1   = 3'd1,
        SRC_D2   = 3'd2,
        SRC_D3   = 3'd3,
        SRC_D4   = 3'd4,
        SRC_DX   = 3'd5,
        SRC_D2X  = 3'd6,
        SRC_LOCK = 3'd7
    } src_code_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              en;
        logic              inv;
    } pair_cfg_t;

    localparam pair_cfg_t CFG_RESET = '{code: SRC_D1, en: 1'b1, inv: 1'b0};

    typedef enum logic {
        DV_WAIT_RISE,
        DV_COUNT
    } div_state_e;

    typedef enum logic {
        PS_STEADY,
        PS_PENDING
    } pair_state_e;

endpackage

// File: rtl/clkmx_cfg_store.sv
module clkmx_cfg_store
    import clkmx_pkg::*;
#(
    parameter int N_SETS  = NUM_SETS,
    parameter int N_PAIRS = NUM_PAIRS,
    parameter int XW      = XVAL_W,
    parameter int XMIN    = X_LO,
    parameter int XMAX    = X_HI
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [$clog2(N_SETS)-1:0]     wr_set,
    input  logic [$clog2(N_PAIRS+2)-1:0]  wr_addr,
    input  logic [XW-1:0]                 wr_data,
    input  logic [$clog2(N_SETS)-1:0]     rd_set,
    output pair_cfg_t                     rd_pairs [N_PAIRS],
    output logic [XW-1:0]                 rd_x,
    output logic                          rd_src
);

    localparam int SET_W  = $clog2(N_SETS);
    localparam int ADDR_W = $clog2(N_PAIRS + 2);
    localparam logic [ADDR_W-1:0] ADDR_X   = ADDR_W'(N_PAIRS);
    localparam logic [ADDR_W-1:0] ADDR_SRC = ADDR_W'(N_PAIRS + 1);

    pair_cfg_t       pcfg  [N_SETS][N_PAIRS];
    logic [XW-1:0]   xval  [N_SETS];
    logic            dsrc  [N_SETS];
    logic [XW-1:0]   x_clamped;

    always_comb begin
        if (wr_data < XW'(XMIN))      x_clamped = XW'(XMIN);
        else if (wr_data > XW'(XMAX)) x_clamped = XW'(XMAX);
        else                          x_clamped = wr_data;
    end

    for (genvar s = 0; s < N_SETS; s++) begin : g_set
        logic set_hit;
        assign set_hit = we && (wr_set == SET_W'(s));

        for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pcfg[s][p] <= CFG_RESET;
                end else if (set_hit && (wr_addr == ADDR_W'(p))) begin
                    pcfg[s][p] <= '{code: wr_data[CODE_W-1:0],
                                    en:   wr_data[CODE_W],
                                    inv:  wr_data[CODE_W+1]};
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                xval[s] <= XW'(XMIN);
                dsrc[s] <= 1'b0;
            end else begin
                if (set_hit && (wr_addr == ADDR_X))   xval[s] <= x_clamped;
                if (set_hit && (wr_addr == ADDR_SRC)) dsrc[s] <= wr_data[0];
            end
        end
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_rd
        assign rd_pairs[p] = pcfg[rd_set][p];
    end
    assign rd_x   = xval[rd_set];
    assign rd_src = dsrc[rd_set];

    p_x_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_x >= XW'(XMIN)) && (rd_x <= XW'(XMAX)));

endmodule

// File: rtl/clkmx_div.sv
module clkmx_div
    import clkmx_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_ev,
    input  logic             rise_ev,
    input  logic             rearm,
    input  logic [CNT_W-1:0] half_n,
    output logic             lvl
);

    div_state_e       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             lvl_q, lvl_n;
    logic [CNT_W-1:0] last_idx;

    assign last_idx = (half_n << 1) - CNT_W'(1);

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        lvl_n = lvl_q;
        unique case (st)
            DV_WAIT_RISE: begin
                lvl_n = 1'b0;
                if (rise_ev && !rearm) begin
                    st_n  = DV_COUNT;
                    cnt_n = '0;
                    lvl_n = 1'b1;
                end
            end
            DV_COUNT: begin
                if (rearm) begin
                    st_n  = DV_WAIT_RISE;
                    cnt_n = '0;
                    lvl_n = 1'b0;
                end else if (edge_ev) begin
                    cnt_n = (cnt >= last_idx) ? '0 : cnt + CNT_W'(1);
                    lvl_n = (cnt_n < half_n);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= DV_WAIT_RISE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_n;
    end

    assign lvl = lvl_q;

    p_hold_between_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DV_COUNT && !edge_ev && !rearm) |=> $stable(lvl_q));

    p_rise_on_source_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_q && !rise_ev) |=> !lvl_q);

endmodule

// File: rtl/clkmx_pair.sv
module clkmx_pair
    import clkmx_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] lvls,
    input  pair_cfg_t        req,
    output logic             out_even,
    output logic             out_odd
);

    pair_state_e st, st_n;
    pair_cfg_t   app, app_n;
    logic        differs, old_low, new_low, swap;
    logic        sel_n, even_n, odd_n;

    assign differs = (req != app);
    assign old_low = !app.en || !lvls[app.code];
    assign new_low = !req.en || !lvls[req.code];
    assign swap    = differs && old_low && new_low;

    always_comb begin
        st_n  = st;
        app_n = app;
        unique case (st)
            PS_STEADY: begin
                if (swap)         app_n = req;
                else if (differs) st_n  = PS_PENDING;
            end
            PS_PENDING: begin
                if (!differs) begin
                    st_n = PS_STEADY;
                end else if (swap) begin
                    app_n = req;
                    st_n  = PS_STEADY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PS_STEADY;
            app <= CFG_RESET;
        end else begin
            st  <= st_n;
            app <= app_n;
        end
    end

    always_comb begin
        sel_n  = lvls[app_n.code];
        odd_n  = app_n.en & sel_n;
        even_n = app_n.en & (sel_n ^ app_n.inv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_even <= 1'b0;
            out_odd  <= 1'b0;
        end else begin
            out_even <= even_n;
            out_odd  <= odd_n;
        end
    end

    p_disabled_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !app.en |-> (!out_even && !out_odd));

    p_complement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (app.en && app.inv) |-> (out_even != out_odd));

    p_swap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(app) |-> !out_odd);

endmodule

// File: rtl/clk_div_matrix.sv
module clk_div_matrix
    import clkmx_pkg::*;
#(
    parameter int N_PAIRS = NUM_PAIRS,
    parameter int N_SETS  = NUM_SETS,
    parameter int XW      = XVAL_W,
    parameter int XMIN    = X_LO,
    parameter int XMAX    = X_HI
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pll_in,
    input  logic                          ref_in,
    input  logic                          lock_in,
    input  logic [$clog2(N_SETS)-1:0]     persona,
    input  logic                          cfg_we,
    input  logic [$clog2(N_SETS)-1:0]     cfg_set,
    input  logic [$clog2(N_PAIRS+2)-1:0]  cfg_addr,
    input  logic [XW-1:0]                 cfg_data,
    output logic [N_PAIRS-1:0]            pair_even,
    output logic [N_PAIRS-1:0]            pair_odd
);

    localparam int CNT_W = $clog2(4 * XMAX);

    pair_cfg_t       act_pairs [N_PAIRS];
    logic [XW-1:0]   act_x, x_prev;
    logic            act_src, src_prev;
    logic            s1, s2, r1, r2, k1, k2;
    logic            edge_ev, rise_ev, rearm;
    logic [CNT_W-1:0] div_n [NUM_DIVS];
    logic [NUM_DIVS-1:0] div_lvl;
    logic [NUM_SRC-1:0]  lvls;

    clkmx_cfg_store #(
        .N_SETS (N_SETS),
        .N_PAIRS(N_PAIRS),
        .XW     (XW),
        .XMIN   (XMIN),
        .XMAX   (XMAX)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wr_set  (cfg_set),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .rd_set  (persona),
        .rd_pairs(act_pairs),
        .rd_x    (act_x),
        .rd_src  (act_src)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0; s2 <= 1'b0;
            r1 <= 1'b0; r2 <= 1'b0;
            k1 <= 1'b0; k2 <= 1'b0;
            x_prev   <= XW'(XMIN);
            src_prev <= 1'b0;
        end else begin
            s1 <= act_src ? ref_in : pll_in;
            s2 <= s1;
            r1 <= ref_in;
            r2 <= r1;
            k1 <= lock_in;
            k2 <= k1;
            x_prev   <= act_x;
            src_prev <= act_src;
        end
    end

    assign edge_ev = s1 ^ s2;
    assign rise_ev = s1 & ~s2;
    assign rearm   = (act_x != x_prev) || (act_src != src_prev);

    for (genvar d = 0; d < NUM_DIVS; d++) begin : g_div
        if (d < 4) begin : g_fixed
            assign div_n[d] = CNT_W'(d + 1);
        end else if (d == 4) begin : g_x
            assign div_n[d] = CNT_W'(act_x);
        end else begin : g_2x
            assign div_n[d] = CNT_W'({act_x, 1'b0});
        end

        clkmx_div #(.CNT_W(CNT_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .edge_ev(edge_ev),
            .rise_ev(rise_ev),
            .rearm  (rearm),
            .half_n (div_n[d]),
            .lvl    (div_lvl[d])
        );
    end

    assign lvls = {k2, div_lvl, r2};

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        clkmx_pair #(.N_SRC(NUM_SRC)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvls    (lvls),
            .req     (act_pairs[p]),
            .out_even(pair_even[p]),
            .out_odd (pair_odd[p])
        );
    end

    p_rearm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (div_lvl == '0));

endmodule

// File: tb/clk_div_matrix_bench.sv
module clk_div_matrix_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_in = 1'b0, ref_in = 1'b0, lock_in = 1'b0;
    logic [1:0] persona = 2'd0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_set = 2'd0;
    logic [2:0] cfg_addr = 3'd0;
    logic [7:0] cfg_data = 8'd0;
    logic [5:0] pair_even, pair_odd;

    clk_div_matrix u_clk_div_matrix (
        .clk(clk), .rst_n(rst_n), .pll_in(pll_in), .ref_in(ref_in),
        .lock_in(lock_in), .persona(persona), .cfg_we(cfg_we),
        .cfg_set(cfg_set), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .pair_even(pair_even), .pair_odd(pair_odd)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    run_cmp  = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R12";

    // ---------------- behavioural reference model ----------------
    int m_code [4][6];
    int m_en   [4][6];
    int m_inv  [4][6];
    int m_x    [4];
    int m_src  [4];
    bit s1, s2, r1, r2, k1, k2;
    int xp, sp;
    int d_arm [6];
    int d_cnt [6];
    bit d_lvl [6];
    int a_code [6];
    int a_en   [6];
    int a_inv  [6];
    logic [5:0] exp_e, exp_o;

    task automatic model_reset();
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 6; p++) begin
                m_code[s][p] = 1; m_en[s][p] = 1; m_inv[s][p] = 0;
            end
            m_x[s] = 5; m_src[s] = 0;
        end
        s1 = 0; s2 = 0; r1 = 0; r2 = 0; k1 = 0; k2 = 0;
        xp = 5; sp = 0;
        for (int d = 0; d < 6; d++) begin d_arm[d] = 0; d_cnt[d] = 0; d_lvl[d] = 0; end
        for (int p = 0; p < 6; p++) begin a_code[p] = 1; a_en[p] = 1; a_inv[p] = 0; end
        exp_e = '0; exp_o = '0;
    endtask

    task automatic model_step();
        int ps, ax, asrc, n, v;
        bit edge_ev, rise_ev, rearm, oldlow, newlow, differ, sel;
        bit lv [8];
        ps = int'(persona);
        ax = m_x[ps];
        asrc = m_src[ps];
        edge_ev = (s1 != s2);
        rise_ev = s1 && !s2;
        rearm = (ax != xp) || (asrc != sp);
        lv[0] = r2;
        for (int d = 0; d < 6; d++) lv[d+1] = d_lvl[d];
        lv[7] = k2;
        for (int d = 0; d < 6; d++) begin
            n = (d < 4) ? d + 1 : ((d == 4) ? ax : 2 * ax);
            if (d_arm[d] == 0) begin
                if (rise_ev && !rearm) begin d_arm[d] = 1; d_cnt[d] = 0; d_lvl[d] = 1; end
                else d_lvl[d] = 0;
            end else if (rearm) begin
                d_arm[d] = 0; d_cnt[d] = 0; d_lvl[d] = 0;
            end else if (edge_ev) begin
                d_cnt[d] = (d_cnt[d] >= 2 * n - 1) ? 0 : d_cnt[d] + 1;
                d_lvl[d] = (d_cnt[d] < n);
            end
        end
        for (int p = 0; p < 6; p++) begin
            differ = (m_code[ps][p] != a_code[p]) || (m_en[ps][p] != a_en[p]) ||
                     (m_inv[ps][p] != a_inv[p]);
            oldlow = (a_en[p] == 0) || !lv[a_code[p]];
            newlow = (m_en[ps][p] == 0) || !lv[m_code[ps][p]];
            if (differ && oldlow && newlow) begin
                a_code[p] = m_code[ps][p]; a_en[p] = m_en[ps][p]; a_inv[p] = m_inv[ps][p];
            end
            sel = lv[a_code[p]];
            exp_o[p] = (a_en[p] != 0) && sel;
            exp_e[p] = (a_en[p] != 0) && (sel ^ (a_inv[p] != 0));
        end
        s2 = s1; s1 = asrc ? ref_in : pll_in;
        r2 = r1; r1 = ref_in;
        k2 = k1; k1 = lock_in;
        xp = ax; sp = asrc;
        if (cfg_we) begin
            v = int'(cfg_data);
            if (cfg_addr < 6) begin
                m_code[cfg_set][cfg_addr] = v & 7;
                m_en[cfg_set][cfg_addr]   = (v >> 3) & 1;
                m_inv[cfg_set][cfg_addr]  = (v >> 4) & 1;
            end else if (cfg_addr == 6) begin
                m_x[cfg_set] = (v < 5) ? 5 : ((v > 130) ? 130 : v);
            end else begin
                m_src[cfg_set] = v & 1;
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    // ---------------- source waveforms ----------------
    int pcnt = 0, rcnt = 0;
    always @(negedge clk) begin
        pcnt <= (pcnt == 1) ? 0 : pcnt + 1;
        rcnt <= (rcnt == 4) ? 0 : rcnt + 1;
        if (pcnt == 1) pll_in <= ~pll_in;
        if (rcnt == 4) ref_in <= ~ref_in;
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && run_cmp && !done) begin
            n_checks++;
            if (pair_even !== exp_e || pair_odd !== exp_o) begin
                n_fail++;
                $display("FAIL %s model compare t=%0t even=%b expected=%b odd=%b expected=%b",
                         cur_req, $time, pair_even, exp_e, pair_odd, exp_o);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int set, input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_set = 2'(set); cfg_addr = 3'(addr); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int pw(input int code, input int en, input int inv);
        return code | (en << 3) | (inv << 4);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int idx, output int hi, output int per);
        bit prev;
        prev = pair_odd[idx];
        forever begin
            @(negedge clk);
            if (pair_odd[idx] && !prev) break;
            prev = pair_odd[idx];
        end
        hi = 1; per = 1; prev = 1'b1;
        forever begin
            @(negedge clk);
            if (pair_odd[idx] && !prev) break;
            per++;
            if (pair_odd[idx]) hi++;
            prev = pair_odd[idx];
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired during %s", cur_req);
            summary();
            $finish;
        end
    end

    initial begin
        int hi, per, mism;
        // R11: reset state
        cyc(4);
        chk("R11 even during reset", int'(pair_even), 0);
        chk("R11 odd during reset", int'(pair_odd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 even after release", int'(pair_even), 0);
        chk("R11 odd after release", int'(pair_odd), 0);
        run_cmp = 1'b1;
        cur_req = "R12";
        cyc(60);

        // program sets (R5); set 0 is live while being written
        cur_req = "R5";
        for (int p = 0; p < 6; p++) wr(0, p, pw(p, 1, 0));
        wr(0, 6, 7);
        wr(1, 0, pw(6, 1, 1)); wr(1, 1, pw(5, 1, 0)); wr(1, 2, pw(5, 1, 1));
        wr(1, 3, pw(7, 1, 0)); wr(1, 4, pw(7, 1, 1)); wr(1, 5, pw(2, 0, 1));
        wr(1, 6, 2);
        wr(2, 0, pw(1, 1, 0)); wr(2, 1, pw(0, 1, 0)); wr(2, 2, pw(5, 1, 0));
        wr(2, 3, pw(6, 1, 0)); wr(2, 4, pw(3, 1, 0)); wr(2, 5, pw(4, 1, 0));
        wr(2, 6, 200); wr(2, 7, 1);
        wr(3, 0, pw(3, 1, 1)); wr(3, 1, pw(7, 1, 0)); wr(3, 2, pw(7, 1, 1));
        wr(3, 3, pw(4, 1, 0)); wr(3, 4, pw(2, 0, 0)); wr(3, 5, pw(5, 1, 0));
        wr(3, 6, 3);

        // R1: every code on its own pair
        cur_req = "R1";
        cyc(600);

        // R7, R8, R6, R10 in personality 1
        cur_req = "R7";
        lock_in = 1'b0;
        persona = 2'd1;
        cyc(40);
        lock_in = 1'b1;
        cyc(20);
        chk("R7 plain lock pair even", int'(pair_even[3]), 1);
        chk("R7 plain lock pair odd", int'(pair_odd[3]), 1);
        chk("R7 inverted lock pair even", int'(pair_even[4]), 0);
        chk("R7 inverted lock pair odd", int'(pair_odd[4]), 1);
        chk("R8 disabled inverted pair even", int'(pair_even[5]), 0);
        chk("R8 disabled inverted pair odd", int'(pair_odd[5]), 0);
        mism = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (pair_odd[1] != pair_odd[2]) mism++;
        end
        chk("R10 pairs on same divider aligned (mismatch count)", mism, 0);
        mism = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (pair_even[2] == pair_odd[2]) mism++;
        end
        chk("R6 inverted pair complementary (equal count)", mism, 0);
        lock_in = 1'b0;
        cyc(10);
        chk("R7 lock low plain odd", int'(pair_odd[3]), 0);
        chk("R7 lock low inverted even", int'(pair_even[4]), 1);

        // R4, R3 in personality 2 (reference-driven, X clamped to 130)
        cur_req = "R4";
        persona = 2'd2;
        cyc(120);
        mism = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pair_odd[0] != pair_odd[1]) mism++;
        end
        chk("R4 ref-counted divide by 1 equals reference", mism, 0);
        cur_req = "R3";
        measure(2, hi, per);
        chk("R3 upper clamp period", per, 1300);
        chk("R3 upper clamp high time", hi, 650);

        // R2, R3 in personality 3
        cur_req = "R2";
        persona = 2'd3;
        cyc(60);
        measure(0, hi, per);
        chk("R2 divide by 3 period", per, 12);
        chk("R2 divide by 3 high time", hi, 6);
        cur_req = "R3";
        measure(5, hi, per);
        chk("R3 lower clamp period", per, 20);
        chk("R3 lower clamp high time", hi, 10);

        // R9: rapid personality switching with live writes
        cur_req = "R9";
        lock_in = 1'b1;
        for (int i = 0; i < 30; i++) begin
            persona = (i % 2 == 0) ? 2'd0 : 2'd1;
            cyc(7);
        end
        lock_in = 1'b0;
        persona = 2'd0;
        wr(0, 0, pw(2, 1, 1));
        wr(0, 3, pw(6, 0, 1));
        cyc(200);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule